// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It takes a bit clock, a frame clock that toggles once per channel slot, and a serial data line. All three are sampled in the system clock domain, so the bit clock must be several times slower than the system clock. A static 3-bit code picks the framing: left-justified, I2S, or right-justified. In right-justified framing the code also gives the sample length. A separate static input selects a compact layout with 16-bit samples and 16 bit clocks per channel.

Every finished sample leaves the block as a 24-bit word with the MSB at bit 23 and the unused low bits cleared. It comes with a one-cycle valid strobe and a channel flag. The block flags an undefined format code, and it flags a frame-clock edge that cuts a channel slot short. After reset it stays silent until the first frame-clock edge has set the slot boundaries.

Top module: `serial_audio_rx`

## Requirements
- R1: With code 000 (left-justified), the left channel is the frame-clock-high slot. The MSB is taken on the first rising bit-clock edge after a frame-clock change, and 24 bits are captured. Bits later in the slot are ignored.
- R2: With code 001 (I2S), the left channel is the frame-clock-low slot. The MSB is taken on the second rising bit-clock edge of the slot, and 24 bits are captured. The first bit of the slot and the bits after the LSB are ignored.
- R3: Codes 100, 101, 110 and 111 select right-justified framing with 16, 18, 20 and 24 bits. Slots are 32 bit clocks long and the frame clock is high for left. The LSB sits on the last bit clock of the slot, and earlier bits of the slot are ignored.
- R4: A captured sample of W bits appears on `smp_o[23:24-W]`, with bits below it zero. `smp_rch_o` is 1 for the right channel and 0 for the left.
- R5: With `pack_i`=1, slots are 16 bit clocks and samples are 16 bits in all three framings. In packed I2S the LSB falls on the first bit clock of the following slot and is tagged with the channel of the slot it started in.
- R6: Codes 010 and 011 drive `fmt_err_o` high and produce no valid strobe.
- R7: When a frame-clock edge arrives while a locked slot holds fewer bit clocks than its nominal length, `frm_err_o` pulses for one cycle. The bit count restarts at the new edge, and the short slot yields no sample.
- R8: After reset, bits received before the first frame-clock edge produce neither samples nor a framing error.
- R9: While and right after reset, `smp_vld_o`, `frm_err_o` and `fmt_err_o` are 0 and `smp_o` is 0.
- R10: Each channel slot yields exactly one valid strobe, one system clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, data taken on its rising edge |
| fclk_i | input | 1 | Frame clock, one level per channel slot |
| sdat_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Static framing and length code |
| pack_i | input | 1 | Static compact 16-clock-slot select |
| smp_o | output | 24 | Received sample, MSB-aligned |
| smp_vld_o | output | 1 | One-cycle strobe for `smp_o` |
| smp_rch_o | output | 1 | Channel of the sample, 1 = right |
| fmt_err_o | output | 1 | Undefined format code selected |
| frm_err_o | output | 1 | One-cycle pulse on a short slot |

## Verification
The bench fills every slot position outside the sample window with random bits. An off-by-one MSB offset, or a right-justified window anchored at the wrong end, then shows up as corrupted samples instead of passing silently. Packed I2S is run end to end, including the final LSB that lands after the last edge. A design that never carries that bit across the slot boundary loses one sample per slot, or tags it with the wrong channel. A long random preamble before the first edge catches a receiver that emits data before it has locked. One deliberately truncated slot checks that the error pulses exactly once and that the counter resynchronizes, so the following slots still decode.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    FRM_LJ   = 2'd0,
    FRM_I2S  = 2'd1,
    FRM_RJ   = 2'd2,
    FRM_NONE = 2'd3
  } frm_e;

  // Map the 3-bit code onto a framing family; 01x has no meaning.
  function automatic frm_e frm_of(logic [2:0] code);
    frm_e f;
    if (code[2])              f = FRM_RJ;
    else if (code[1])         f = FRM_NONE;
    else if (code[0])         f = FRM_I2S;
    else                      f = FRM_LJ;
    return f;
  endfunction

endpackage

// File: rtl/sarx_in_sync.sv
module sarx_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic sdat_i,
  output logic bit_stb_o,
  output logic fclk_o,
  output logic sdat_o
);

  logic [STAGES:0]   bclk_q, bclk_n;
  logic [STAGES-1:0] fclk_q, fclk_n;
  logic [STAGES-1:0] sdat_q, sdat_n;

  always_comb begin
    bclk_n = {bclk_q[STAGES-1:0], bclk_i};
    fclk_n = {fclk_q[STAGES-2:0], fclk_i};
    sdat_n = {sdat_q[STAGES-2:0], sdat_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      fclk_q <= '0;
      sdat_q <= '0;
    end else begin
      bclk_q <= bclk_n;
      fclk_q <= fclk_n;
      sdat_q <= sdat_n;
    end
  end

  // Frame clock and data leave at the same depth as the bit-clock level
  // used for edge detection, so all three describe the same bit.
  assign bit_stb_o = bclk_q[STAGES-1] & ~bclk_q[STAGES];
  assign fclk_o    = fclk_q[STAGES-1];
  assign sdat_o    = sdat_q[STAGES-1];

  // R10: two strobes never sit in adjacent cycles
  a_r10_stb_spaced: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/sarx_fmt_dec.sv
module sarx_fmt_dec
  import serial_audio_rx_pkg::*;
#(
  parameter int OUT_W     = 24,
  parameter int FULL_SLOT = 32,
  parameter int PACK_SLOT = 16,
  parameter int PACK_W    = 16,
  parameter int WW        = $clog2(OUT_W + 1),
  parameter int CW        = $clog2(2 * FULL_SLOT)
) (
  input  logic [2:0]    code_i,
  input  logic          pack_i,
  output frm_e          frm_o,
  output logic          bad_o,
  output logic          wrap_o,
  output logic [WW-1:0] width_o,
  output logic [CW-1:0] slot_o,
  output logic [CW-1:0] first_o,
  output logic [CW-1:0] last_o
);

  localparam logic [WW-1:0] W_FULL = WW'(OUT_W);
  localparam logic [WW-1:0] W_PACK = WW'(PACK_W);
  localparam logic [CW-1:0] S_FULL = CW'(FULL_SLOT);
  localparam logic [CW-1:0] S_PACK = CW'(PACK_SLOT);

  logic [WW-1:0] rj_w;

  always_comb begin
    unique case (code_i[1:0])
      2'b00:   rj_w = WW'(16);
      2'b01:   rj_w = WW'(18);
      2'b10:   rj_w = WW'(20);
      default: rj_w = WW'(24);
    endcase
  end

  always_comb begin
    frm_o   = frm_of(code_i);
    bad_o   = (frm_o == FRM_NONE);
    slot_o  = pack_i ? S_PACK : S_FULL;
    if (pack_i)                width_o = W_PACK;
    else if (frm_o == FRM_RJ)  width_o = rj_w;
    else                       width_o = W_FULL;
    unique case (frm_o)
      FRM_I2S: first_o = CW'(1);
      FRM_RJ:  first_o = slot_o - CW'(width_o);
      default: first_o = '0;
    endcase
    last_o = first_o + CW'(width_o) - CW'(1);
    wrap_o = (last_o >= slot_o);
  end

endmodule

// File: rtl/sarx_slot_ctr.sv
module sarx_slot_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          bit_stb_i,
  input  logic          fclk_i,
  input  logic [CW-1:0] slot_i,
  output logic [CW-1:0] idx_o,
  output logic          edge_o,
  output logic          early_o,
  output logic          locked_o,
  output logic          frm_err_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_n;
  logic          fprev_q, fprev_n;
  logic          seen_q, seen_n;
  logic          lock_q, lock_n;
  logic          err_q, err_n;

  always_comb begin
    edge_o   = seen_q && (fclk_i != fprev_q);
    early_o  = edge_o && lock_q && (cnt_q < slot_i - CW'(1));
    if (edge_o)                idx_o = '0;
    else if (cnt_q == CNT_MAX) idx_o = CNT_MAX;
    else                       idx_o = cnt_q + CW'(1);
    locked_o = lock_q || edge_o;

    cnt_n   = cnt_q;
    fprev_n = fprev_q;
    seen_n  = seen_q;
    lock_n  = lock_q;
    err_n   = 1'b0;
    if (bit_stb_i) begin
      cnt_n   = idx_o;
      fprev_n = fclk_i;
      seen_n  = 1'b1;
      lock_n  = locked_o;
      err_n   = early_o;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fprev_q <= 1'b0;
      seen_q  <= 1'b0;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      fprev_q <= fprev_n;
      seen_q  <= seen_n;
      lock_q  <= lock_n;
      err_q   <= err_n;
    end
  end

  assign frm_err_o = err_q;

  // R7: framing error is a single-cycle pulse
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |=> !err_q);
  // R7: the count restarts on the edge that raised the error
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |-> (cnt_q == '0));
  // R8: no framing error before the first boundary has been seen
  a_r8_err_needs_lock: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |-> $past(lock_q));

endmodule

// File: rtl/sarx_capture.sv
module sarx_capture #(
  parameter int OUT_W = 24,
  parameter int WW    = 5,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             sdat_i,
  input  logic [CW-1:0]    idx_i,
  input  logic             edge_i,
  input  logic             early_i,
  input  logic             locked_i,
  input  logic             rch_i,
  input  logic             bad_i,
  input  logic             wrap_i,
  input  logic [WW-1:0]    width_i,
  input  logic [CW-1:0]    slot_i,
  input  logic [CW-1:0]    first_i,
  input  logic [CW-1:0]    last_i,
  output logic [OUT_W-1:0] smp_o,
  output logic             vld_o,
  output logic             rch_o
);

  logic [OUT_W-1:0] sh_q, sh_n, sh_nxt;
  logic [OUT_W-1:0] smp_q, smp_n;
  logic             vld_q, vld_n;
  logic             rch_q, rch_n;
  logic             pend_q, pend_n;
  logic             prch_q, prch_n;
  logic [CW-1:0]    last_in;
  logic             in_data, emit_in, emit_wr, pend_set;
  logic [OUT_W-1:0] lo_mask;

  always_comb begin
    last_in  = wrap_i ? slot_i - CW'(1) : last_i;
    in_data  = locked_i && !bad_i && (idx_i >= first_i) && (idx_i <= last_in);
    emit_in  = in_data && !wrap_i && (idx_i == last_i);
    emit_wr  = pend_q && edge_i && !early_i && !bad_i;
    pend_set = wrap_i && in_data && (idx_i == last_in);
    sh_nxt   = {sh_q[OUT_W-2:0], sdat_i};

    sh_n   = sh_q;
    smp_n  = smp_q;
    rch_n  = rch_q;
    vld_n  = 1'b0;
    pend_n = pend_q;
    prch_n = prch_q;
    if (bit_stb_i) begin
      if (in_data || emit_wr) sh_n = sh_nxt;
      vld_n = emit_in || emit_wr;
      if (vld_n) begin
        smp_n = sh_nxt << (OUT_W - int'(width_i));
        rch_n = emit_wr ? prch_q : rch_i;
      end
      pend_n = pend_set;
      if (pend_set) prch_n = rch_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      smp_q  <= '0;
      vld_q  <= 1'b0;
      rch_q  <= 1'b0;
      pend_q <= 1'b0;
      prch_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      smp_q  <= smp_n;
      vld_q  <= vld_n;
      rch_q  <= rch_n;
      pend_q <= pend_n;
      prch_q <= prch_n;
    end
  end

  assign smp_o = smp_q;
  assign vld_o = vld_q;
  assign rch_o = rch_q;

  assign lo_mask = ~({OUT_W{1'b1}} << (OUT_W - int'(width_i)));

  // R4: bits below the received width are clear on every output word
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |-> ((smp_q & lo_mask) == '0));
  // R6: an undefined code never yields a sample
  a_r6_bad_silent: assert property (@(posedge clk) disable iff (!rst_ni)
    bad_i |-> !vld_q);
  // R10: valid strobe lasts one cycle
  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    vld_q |=> !vld_q);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int OUT_W     = 24,
  parameter int FULL_SLOT = 32,
  parameter int PACK_SLOT = 16,
  parameter int PACK_W    = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             fclk_i,
  input  logic             sdat_i,
  input  logic [2:0]       fmt_i,
  input  logic             pack_i,
  output logic [OUT_W-1:0] smp_o,
  output logic             smp_vld_o,
  output logic             smp_rch_o,
  output logic             fmt_err_o,
  output logic             frm_err_o
);

  localparam int WW = $clog2(OUT_W + 1);
  localparam int CW = $clog2(2 * FULL_SLOT);

  logic [1:0]    rs_q;
  logic          rst_ni;
  logic          bit_stb, fclk_s, sdat_s;
  frm_e          frm;
  logic          bad, wrap;
  logic [WW-1:0] width;
  logic [CW-1:0] slot, first, last, idx;
  logic          edge_s, early, locked, rch;
  logic          ferr_q, ferr_n;

  // Reset: asserted at once, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  sarx_in_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .bclk_i   (bclk_i),
    .fclk_i   (fclk_i),
    .sdat_i   (sdat_i),
    .bit_stb_o(bit_stb),
    .fclk_o   (fclk_s),
    .sdat_o   (sdat_s)
  );

  sarx_fmt_dec #(
    .OUT_W(OUT_W), .FULL_SLOT(FULL_SLOT), .PACK_SLOT(PACK_SLOT),
    .PACK_W(PACK_W), .WW(WW), .CW(CW)
  ) u_dec (
    .code_i (fmt_i),
    .pack_i (pack_i),
    .frm_o  (frm),
    .bad_o  (bad),
    .wrap_o (wrap),
    .width_o(width),
    .slot_o (slot),
    .first_o(first),
    .last_o (last)
  );

  sarx_slot_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .bit_stb_i(bit_stb),
    .fclk_i   (fclk_s),
    .slot_i   (slot),
    .idx_o    (idx),
    .edge_o   (edge_s),
    .early_o  (early),
    .locked_o (locked),
    .frm_err_o(frm_err_o)
  );

  // Left is frame-clock low in I2S, high otherwise.
  assign rch = (frm == FRM_I2S) ? fclk_s : ~fclk_s;

  sarx_capture #(.OUT_W(OUT_W), .WW(WW), .CW(CW)) u_cap (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .bit_stb_i(bit_stb),
    .sdat_i   (sdat_s),
    .idx_i    (idx),
    .edge_i   (edge_s),
    .early_i  (early),
    .locked_i (locked),
    .rch_i    (rch),
    .bad_i    (bad),
    .wrap_i   (wrap),
    .width_i  (width),
    .slot_i   (slot),
    .first_i  (first),
    .last_i   (last),
    .smp_o    (smp_o),
    .vld_o    (smp_vld_o),
    .rch_o    (smp_rch_o)
  );

  assign ferr_n = bad;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ferr_q <= 1'b0;
    else         ferr_q <= ferr_n;
  end
  assign fmt_err_o = ferr_q;

  // R9: the valid and error outputs stay low while reset is applied
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_ni |=> (!smp_vld_o && !frm_err_o));

endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, fclk, sdat;
  logic [2:0]  fmt;
  logic        pack;
  logic [23:0] smp;
  logic        vld, rch, fmt_err, frm_err;

  always #2.5 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdat_i(sdat),
    .fmt_i(fmt), .pack_i(pack), .smp_o(smp), .smp_vld_o(vld),
    .smp_rch_o(rch), .fmt_err_o(fmt_err), .frm_err_o(frm_err)
  );

  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [24:0] exp_q[$];
  int          errs_seen;
  string       cur_tag;
  logic        bit_a[0:511];
  logic        fr_a[0:511];
  int          st_a[0:31];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string msg, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", msg, act, expv);
    end
  endtask

  function automatic logic [23:0] rnd24();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:7];
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && frm_err) errs_seen++;
    if (rst_n && vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_tag, " R10 unexpected sample"}, {7'd0, rch, smp}, 32'd0);
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        chk({rch, smp} == e, {cur_tag, " R4 sample"}, {7'd0, rch, smp}, {7'd0, e});
      end
    end
  end

  task automatic do_reset(input logic [2:0] code, input logic pk);
    rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdat = 1'b0;
    fmt = code; pack = pk;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic drive(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bclk = 1'b0; fclk = fr_a[i]; sdat = bit_a[i];
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    bclk = 1'b0;
  endtask

  task automatic run_case(input logic [2:0] code, input logic pk, input int nfr,
                          input int short_at, input string tag, input int exp_err);
    int   kind, w, slen, off, pos, len;
    logic lvl;
    logic [23:0] v, msk;
    cur_tag = tag;
    kind = (code == 3'b000) ? 0 : (code == 3'b001) ? 1 : code[2] ? 2 : 3;
    slen = pk ? 16 : 32;
    w    = pk ? 16 : (kind == 2) ? ((code[1:0] == 2'b11) ? 24 : 16 + 2 * code[1:0]) : 24;
    off  = (kind == 1) ? 1 : (kind == 2) ? slen - w : 0;
    lvl  = (kind == 1) ? 1'b0 : 1'b1;
    do_reset(code, pk);
    errs_seen = 0;
    pos = 0;
    for (int i = 0; i < 30; i++) begin            // R8 preamble, not locked
      fr_a[pos] = ~lvl; bit_a[pos] = rnd24()[5]; pos++;
    end
    for (int s = 0; s < 2 * nfr; s++) begin
      st_a[s] = pos;
      len = (s == short_at) ? 10 : slen;
      for (int b = 0; b < len; b++) begin
        fr_a[pos] = (s % 2 == 0) ? lvl : ~lvl; bit_a[pos] = rnd24()[9]; pos++;
      end
    end
    for (int i = 0; i < 2; i++) begin
      fr_a[pos] = lvl; bit_a[pos] = rnd24()[3]; pos++;
    end
    msk = 24'hFF_FFFF >> (24 - w);
    for (int s = 0; s < 2 * nfr; s++) begin
      if (s == short_at) continue;
      v = rnd24() & msk;
      for (int k = 0; k < w; k++) bit_a[st_a[s] + off + k] = v[w - 1 - k];
      if (kind != 3) exp_q.push_back({(s % 2 == 1), v << (24 - w)});
    end
    drive(pos);
    repeat (20) @(negedge clk);
    chk(fmt_err == (kind == 3), {tag, " R6 fmt_err level"}, {31'd0, fmt_err}, (kind == 3));
    chk(errs_seen == exp_err, {tag, " R7 R8 framing error count"}, errs_seen, exp_err);
    chk(exp_q.size() == 0, {tag, " R10 missing samples"}, exp_q.size(), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    cur_tag = "reset";
    errs_seen = 0;
    do_reset(3'b000, 1'b0);
    chk(!vld && !frm_err && !fmt_err && smp == '0, "R9 reset state",
        {4'd0, vld, frm_err, fmt_err, 1'b0, smp}, 32'd0);
    run_case(3'b000, 1'b0, 3, -1, "R1 LJ",        0);
    run_case(3'b001, 1'b0, 3, -1, "R2 I2S",       0);
    run_case(3'b100, 1'b0, 3, -1, "R3 RJ16",      0);
    run_case(3'b101, 1'b0, 3, -1, "R3 RJ18",      0);
    run_case(3'b110, 1'b0, 3, -1, "R3 RJ20",      0);
    run_case(3'b111, 1'b0, 3, -1, "R3 RJ24",      0);
    run_case(3'b000, 1'b1, 3, -1, "R5 packed LJ", 0);
    run_case(3'b001, 1'b1, 3, -1, "R5 packed I2S", 0);
    run_case(3'b110, 1'b1, 3, -1, "R5 packed RJ", 0);
    run_case(3'b010, 1'b0, 2, -1, "R6 code010",   0);
    run_case(3'b011, 1'b1, 2, -1, "R6 code011",   0);
    run_case(3'b000, 1'b0, 3, 1,  "R7 short LJ",  1);
    run_case(3'b100, 1'b0, 3, 2,  "R7 short RJ",  1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s act=1 exp=0", cur_tag);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule